// File: doc/BRIEF.md
# Code-Block Parameter Handshake Controller

This controller sits at the front of a block codec. It runs two ready/valid handshakes, one for the per-block configuration and one for the packet data stream. The configuration handshake captures a codeword length code, a CRC selector, an interleave flag, a frozen-position mask, a parity-check mask and a 16-bit identifier into a register bank that the codec datapath reads. The data handshake never lets a packet overlap a configuration change. For each data beat that is taken, the controller raises an acceptance strobe for downstream storage.

After reset the controller asks for a configuration and refuses packet data until it has latched a legal set. From then on, every idle gap between packets offers a configuration window. A new set is optional: if none arrives, the bank keeps the previous values. A configuration arriving in the same cycle as a data beat wins, and the data beat is dropped. The controller also leaves a one-cycle gap after each bank load and after each accepted end of packet.

Top module: `cbp_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `cp_req`=1, `cp_ready`=1, `pk_ready`=0 and `len_err`=0, and every bank output is zero.
- R2: A configuration valid is honoured only when `cp_ready` was high in the previous cycle. While a packet is in progress `cp_ready` is low, so any configuration presented then is not latched.
- R3: If `cp_valid` stays high for several cycles, only the values from its first cycle are latched.
- R4: No data beat is accepted until a legal configuration has been latched. `cp_req` falls and `pk_ready` rises after that first load.
- R5: A new configuration is optional for every block after the first. A packet sent without one runs with the bank unchanged.
- R6: When a configuration valid and a data beat arrive together and both readies were high in the previous cycle, the configuration is latched and the data beat is not accepted.
- R7: A data beat in the cycle right after a bank load is ignored. A data beat in the cycle right after an accepted end-of-packet beat is also ignored.
- R8: Once `pk_ready` is high it stays high, including through idle cycles within a packet, until the end-of-packet beat has been accepted.
- R9: The codeword length is N = 16 << `cp_len`. Latched frozen-mask bits at position N and above read as zero.
- R10: The identifier is latched only when the CRC selector is 7. For any other selector the bank identifier reads as zero.
- R11: A length code of 0 or 7 is illegal. It produces a one-cycle `len_err` pulse in the cycle after it is presented, leaves the bank and `cp_req` unchanged, and blocks no data.
- R12: A packet starts only on a beat with `pk_sop` high. An idle-state beat without `pk_sop` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cp_req | output | 1 | No legal configuration yet; one is required |
| cp_ready | output | 1 | Configuration window open (honoured next cycle) |
| cp_valid | input | 1 | Configuration valid |
| cp_len | input | 3 | Length code, N = 16 << code, legal 1..6 |
| cp_crc | input | 3 | CRC selector, 0 = off, 7 = identifier-seeded 24-bit |
| cp_ilv | input | 1 | Interleave enable |
| cp_frozen | input | 1024 | Frozen-position mask |
| cp_pchk | input | 28 | Parity-check position mask |
| cp_ident | input | 16 | Identifier for CRC selector 7 |
| pk_ready | output | 1 | Data sink ready (honoured next cycle) |
| pk_valid | input | 1 | Data beat valid |
| pk_sop | input | 1 | First beat of packet |
| pk_eop | input | 1 | Last beat of packet |
| pk_take | output | 1 | Data beat accepted this cycle |
| len_err | output | 1 | Illegal length code pulse |
| blk_len | output | 3 | Latched length code |
| blk_crc | output | 3 | Latched CRC selector |
| blk_ilv | output | 1 | Latched interleave flag |
| blk_frozen | output | 1024 | Latched frozen mask, cleared at and above N |
| blk_pchk | output | 28 | Latched parity-check mask |
| blk_ident | output | 16 | Latched identifier, zero unless selector 7 |

## Verification
The bench walks every length code from 0 to 7 with an all-ones frozen mask and compares the population count of the latched mask with 16 << code. A decoder that sizes N wrongly shows a wrong count, and one that accepts code 0 or 7 corrupts the bank or clears the request flag early. Targeted sequences present a configuration and a data beat together, data right after a load, and data right after an end-of-packet beat. A design that lets any of these through raises `pk_take` where it must stay low. A held configuration valid with changing values would, in a design that does not detect the first cycle, leave the last value in the bank. Other sequences send a configuration during a packet and an idle beat without a start marker; a careless design would change its configuration mid-packet or start a packet without the marker.

// File: rtl/cbp_pkg.sv
`timescale 1ns/1ps
package cbp_pkg;
  localparam int unsigned LEN_W = 3;
  localparam int unsigned CRC_W = 3;

  typedef enum logic [CRC_W-1:0] {
    CRC_NONE   = 3'd0,
    CRC_A24    = 3'd1,
    CRC_B24    = 3'd2,
    CRC_C24    = 3'd3,
    CRC_16     = 3'd4,
    CRC_11     = 3'd5,
    CRC_6      = 3'd6,
    CRC_C24_ID = 3'd7
  } crc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } hs_st_e;
endpackage

// File: rtl/cbp_len_dec.sv
`timescale 1ns/1ps
module cbp_len_dec #(
  parameter int unsigned MAX_LOG = 10,
  localparam int unsigned FRZ_W = 1 << MAX_LOG,
  localparam int unsigned MAX_CODE = MAX_LOG - 4
) (
  input  logic [cbp_pkg::LEN_W-1:0] code,
  output logic                      legal,
  output logic [FRZ_W-1:0]          mask
);
  logic [31:0] n_bits;

  always_comb begin
    n_bits = 32'd1 << (32'(code) + 32'd4);
    legal  = (int'(code) >= 1) && (int'(code) <= int'(MAX_CODE));
  end

  for (genvar i = 0; i < int'(FRZ_W); i++) begin : g_mask
    assign mask[i] = (32'(i) < n_bits);
  end
endmodule

// File: rtl/cbp_hs_fsm.sv
`timescale 1ns/1ps
module cbp_hs_fsm
  import cbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cp_valid,
  input  logic cp_legal,
  input  logic pk_valid,
  input  logic pk_sop,
  input  logic pk_eop,
  output logic cp_req,
  output logic cp_ready,
  output logic pk_ready,
  output logic pk_take,
  output logic cfg_load,
  output logic len_err
);
  hs_st_e st_q, st_d;
  logic have_q, have_d;
  logic cpv_q;
  logic cprdy_q;
  logic pkrdy_q;
  logic blk_q, blk_d;
  logic err_q, err_d;
  logic cp_hit;

  always_comb begin
    cp_ready = (st_q == ST_IDLE);
    pk_ready = have_q;
    cp_req   = !have_q;
    cp_hit   = cp_valid && !cpv_q && cprdy_q && (st_q == ST_IDLE);
    cfg_load = cp_hit && cp_legal;
    pk_take  = pk_valid && pkrdy_q && !blk_q && !cp_hit &&
               ((st_q == ST_BUSY) || pk_sop);
    len_err  = err_q;
  end

  always_comb begin
    st_d = st_q;
    if (pk_take) begin
      if (st_q == ST_IDLE && !pk_eop) st_d = ST_BUSY;
      else if (st_q == ST_BUSY && pk_eop) st_d = ST_IDLE;
    end
    have_d = have_q | cfg_load;
    blk_d  = cfg_load | (pk_take & pk_eop);
    err_d  = cp_hit & !cp_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      have_q  <= 1'b0;
      cpv_q   <= 1'b0;
      cprdy_q <= 1'b0;
      pkrdy_q <= 1'b0;
      blk_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      have_q  <= have_d;
      cpv_q   <= cp_valid;
      cprdy_q <= cp_ready;
      pkrdy_q <= pk_ready;
      blk_q   <= blk_d;
      err_q   <= err_d;
    end
  end

  // R4: no data while a configuration is still requested
  p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_req |-> !pk_take);
  // R7: load is followed by a dead data cycle
  p_gap_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !pk_take);
  // R3: a held valid never loads twice in a row
  p_first_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_load);
  // R8: sink ready never drops once raised
  p_hold_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pk_ready |=> pk_ready);
  // R2: configuration window closed while a packet runs
  p_no_cfg_in_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_take && !pk_eop) |=> !cfg_load);
endmodule

// File: rtl/cbp_bank.sv
`timescale 1ns/1ps
module cbp_bank
  import cbp_pkg::*;
#(
  parameter int unsigned FRZ_W = 1024,
  parameter int unsigned PC_W  = 28,
  parameter int unsigned ID_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic [CRC_W-1:0] crc_in,
  input  logic             ilv_in,
  input  logic [FRZ_W-1:0] frz_in,
  input  logic [FRZ_W-1:0] frz_keep,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [ID_W-1:0]  id_in,
  output logic [LEN_W-1:0] len_q,
  output logic [CRC_W-1:0] crc_q,
  output logic             ilv_q,
  output logic [FRZ_W-1:0] frz_q,
  output logic [PC_W-1:0]  pc_q,
  output logic [ID_W-1:0]  id_q
);
  logic [FRZ_W-1:0] frz_d;
  logic [ID_W-1:0]  id_d;

  always_comb begin
    frz_d = frz_in & frz_keep;
    id_d  = (crc_e'(crc_in) == CRC_C24_ID) ? id_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      crc_q <= '0;
      ilv_q <= 1'b0;
      frz_q <= '0;
      pc_q  <= '0;
      id_q  <= '0;
    end else if (load) begin
      len_q <= len_in;
      crc_q <= crc_in;
      ilv_q <= ilv_in;
      frz_q <= frz_d;
      pc_q  <= pc_in;
      id_q  <= id_d;
    end
  end

  // R10: identifier only kept for the identifier-seeded CRC
  p_id_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_e'(crc_q) != CRC_C24_ID) |-> (id_q == '0));
endmodule

// File: rtl/cbp_ctrl.sv
`timescale 1ns/1ps
module cbp_ctrl
  import cbp_pkg::*;
#(
  parameter int unsigned MAX_LOG = 10,
  parameter int unsigned PC_W    = 28,
  parameter int unsigned ID_W    = 16,
  localparam int unsigned FRZ_W  = 1 << MAX_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             cp_req,
  output logic             cp_ready,
  input  logic             cp_valid,
  input  logic [LEN_W-1:0] cp_len,
  input  logic [CRC_W-1:0] cp_crc,
  input  logic             cp_ilv,
  input  logic [FRZ_W-1:0] cp_frozen,
  input  logic [PC_W-1:0]  cp_pchk,
  input  logic [ID_W-1:0]  cp_ident,
  output logic             pk_ready,
  input  logic             pk_valid,
  input  logic             pk_sop,
  input  logic             pk_eop,
  output logic             pk_take,
  output logic             len_err,
  output logic [LEN_W-1:0] blk_len,
  output logic [CRC_W-1:0] blk_crc,
  output logic             blk_ilv,
  output logic [FRZ_W-1:0] blk_frozen,
  output logic [PC_W-1:0]  blk_pchk,
  output logic [ID_W-1:0]  blk_ident
);
  logic             in_legal;
  logic [FRZ_W-1:0] in_keep;
  logic             cfg_load;
  logic             bank_legal;
  logic [FRZ_W-1:0] bank_keep;

  cbp_len_dec #(.MAX_LOG(MAX_LOG)) u_dec_in (
    .code  (cp_len),
    .legal (in_legal),
    .mask  (in_keep)
  );

  cbp_hs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cp_valid (cp_valid),
    .cp_legal (in_legal),
    .pk_valid (pk_valid),
    .pk_sop   (pk_sop),
    .pk_eop   (pk_eop),
    .cp_req   (cp_req),
    .cp_ready (cp_ready),
    .pk_ready (pk_ready),
    .pk_take  (pk_take),
    .cfg_load (cfg_load),
    .len_err  (len_err)
  );

  cbp_bank #(.FRZ_W(FRZ_W), .PC_W(PC_W), .ID_W(ID_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .len_in   (cp_len),
    .crc_in   (cp_crc),
    .ilv_in   (cp_ilv),
    .frz_in   (cp_frozen),
    .frz_keep (in_keep),
    .pc_in    (cp_pchk),
    .id_in    (cp_ident),
    .len_q    (blk_len),
    .crc_q    (blk_crc),
    .ilv_q    (blk_ilv),
    .frz_q    (blk_frozen),
    .pc_q     (blk_pchk),
    .id_q     (blk_ident)
  );

  cbp_len_dec #(.MAX_LOG(MAX_LOG)) u_dec_bank (
    .code  (blk_len),
    .legal (bank_legal),
    .mask  (bank_keep)
  );

  // R9: stored frozen mask never extends past the stored length
  p_frozen_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_frozen & ~bank_keep) == '0);
  // R11: an illegal code leaves the stored length untouched
  p_err_keeps_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $stable(blk_len));
  // R11: a stored non-zero length is always a legal one
  p_bank_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_len != '0) |-> bank_legal);
endmodule

// File: tb/cbp_ctrl_tb.sv
`timescale 1ns/1ps
module cbp_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cp_valid, cp_ilv, pk_valid, pk_sop, pk_eop;
  logic [2:0] cp_len, cp_crc;
  logic [1023:0] cp_frozen;
  logic [27:0] cp_pchk;
  logic [15:0] cp_ident;
  logic cp_req, cp_ready, pk_ready, pk_take, len_err;
  logic [2:0] blk_len, blk_crc;
  logic blk_ilv;
  logic [1023:0] blk_frozen;
  logic [27:0] blk_pchk;
  logic [15:0] blk_ident;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cbp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cp_req(cp_req), .cp_ready(cp_ready), .cp_valid(cp_valid),
    .cp_len(cp_len), .cp_crc(cp_crc), .cp_ilv(cp_ilv),
    .cp_frozen(cp_frozen), .cp_pchk(cp_pchk), .cp_ident(cp_ident),
    .pk_ready(pk_ready), .pk_valid(pk_valid), .pk_sop(pk_sop), .pk_eop(pk_eop),
    .pk_take(pk_take), .len_err(len_err),
    .blk_len(blk_len), .blk_crc(blk_crc), .blk_ilv(blk_ilv),
    .blk_frozen(blk_frozen), .blk_pchk(blk_pchk), .blk_ident(blk_ident)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic cfg(input logic v, input logic [2:0] l, input logic [2:0] c, input logic [15:0] id);
    cp_valid = v; cp_len = l; cp_crc = c; cp_ident = id;
  endtask

  task automatic pk(input logic v, input logic s, input logic e);
    pk_valid = v; pk_sop = s; pk_eop = e;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_len, exp_crc, exp_pop;
    bit have;
    rst_n = 1'b0;
    cfg(1'b0, 3'd0, 3'd0, 16'h0);
    cp_ilv = 1'b0; cp_frozen = '1; cp_pchk = 28'h0000_0A2;
    pk(1'b0, 1'b0, 1'b0);
    repeat (3) nxt();
    rst_n = 1'b1;
    nxt();
    // R1 reset state
    chk("R1 req", 64'(cp_req), 64'd1);
    chk("R1 cp_ready", 64'(cp_ready), 64'd1);
    chk("R1 pk_ready", 64'(pk_ready), 64'd0);
    chk("R1 len_err", 64'(len_err), 64'd0);
    chk("R1 bank len", 64'(blk_len), 64'd0);
    chk("R1 bank frozen", 64'($countones(blk_frozen)), 64'd0);

    // R4 data refused before any configuration
    pk(1'b1, 1'b1, 1'b0);
    #1 chk("R4 no take unconfigured", 64'(pk_take), 64'd0);
    nxt(); pk(1'b0, 1'b0, 1'b0);
    nxt();

    // R9 R11 sweep of every length code
    exp_len = 0; exp_crc = 0; exp_pop = 0; have = 1'b0;
    for (int code = 0; code < 8; code++) begin
      cfg(1'b1, 3'(code), 3'(code), 16'h1000 + 16'(code));
      nxt();
      cfg(1'b0, 3'd0, 3'd0, 16'h0);
      if (code >= 1 && code <= 6) begin
        exp_len = code; exp_crc = code; exp_pop = 16 << code; have = 1'b1;
      end
      chk("R11 len_err", 64'(len_err), (code == 0 || code == 7) ? 64'd1 : 64'd0);
      chk("R11 req", 64'(cp_req), have ? 64'd0 : 64'd1);
      chk("R9 len", 64'(blk_len), 64'(exp_len));
      chk("R9 crc", 64'(blk_crc), 64'(exp_crc));
      chk("R9 frozen count", 64'($countones(blk_frozen)), 64'(exp_pop));
      chk("R10 id zero", 64'(blk_ident), 64'd0);
      nxt();
      chk("R11 pulse ends", 64'(len_err), 64'd0);
    end
    chk("R4 sink ready after load", 64'(pk_ready), 64'd1);

    // R10 identifier kept only for selector 7
    cfg(1'b1, 3'd2, 3'd7, 16'hBEEF);
    nxt(); cfg(1'b0, 3'd0, 3'd0, 16'h0);
    chk("R10 id kept", 64'(blk_ident), 64'hBEEF);
    chk("R9 len2 count", 64'($countones(blk_frozen)), 64'd64);
    nxt();
    cfg(1'b1, 3'd2, 3'd3, 16'hBEEF);
    nxt(); cfg(1'b0, 3'd0, 3'd0, 16'h0);
    chk("R10 id dropped", 64'(blk_ident), 64'd0);
    nxt();

    // R3 held valid latches first values only
    cfg(1'b1, 3'd1, 3'd2, 16'h0);
    nxt(); cfg(1'b1, 3'd2, 3'd4, 16'h0);
    chk("R3 first len", 64'(blk_len), 64'd1);
    nxt(); cfg(1'b1, 3'd3, 3'd5, 16'h0);
    chk("R3 held len", 64'(blk_len), 64'd1);
    nxt(); cfg(1'b0, 3'd0, 3'd0, 16'h0);
    chk("R3 final len", 64'(blk_len), 64'd1);
    chk("R3 final crc", 64'(blk_crc), 64'd2);
    nxt(); nxt();

    // R6 simultaneous: configuration wins
    cfg(1'b1, 3'd4, 3'd1, 16'h0);
    pk(1'b1, 1'b1, 1'b0);
    #1 chk("R6 data dropped", 64'(pk_take), 64'd0);
    nxt(); cfg(1'b0, 3'd0, 3'd0, 16'h0);
    chk("R6 cfg taken", 64'(blk_len), 64'd4);
    #1 chk("R7 gap after load", 64'(pk_take), 64'd0);
    nxt();
    #1 chk("R12 sop starts packet", 64'(pk_take), 64'd1);
    nxt(); pk(1'b1, 1'b0, 1'b0);
    cfg(1'b1, 3'd2, 3'd0, 16'h0);
    #1 chk("R8 mid beat", 64'(pk_take), 64'd1);
    chk("R8 cp_ready low", 64'(cp_ready), 64'd0);
    nxt(); pk(1'b0, 1'b0, 1'b0); cfg(1'b0, 3'd0, 3'd0, 16'h0);
    chk("R2 cfg ignored in packet", 64'(blk_len), 64'd4);
    chk("R8 ready held in gap", 64'(pk_ready), 64'd1);
    nxt(); pk(1'b1, 1'b0, 1'b1);
    #1 chk("R8 eop beat", 64'(pk_take), 64'd1);
    nxt(); pk(1'b1, 1'b1, 1'b0);
    #1 chk("R7 gap after eop", 64'(pk_take), 64'd0);
    chk("R2 idle window", 64'(cp_ready), 64'd1);
    nxt(); pk(1'b1, 1'b0, 1'b0);
    #1 chk("R12 no sop refused", 64'(pk_take), 64'd0);
    nxt(); pk(1'b1, 1'b1, 1'b1);
    #1 chk("R5 reuse single beat", 64'(pk_take), 64'd1);
    chk("R5 bank kept", 64'(blk_len), 64'd4);
    chk("R5 req low", 64'(cp_req), 64'd0);
    nxt(); pk(1'b0, 1'b0, 1'b0);
    chk("R5 idle after single beat", 64'(cp_ready), 64'd1);
    nxt();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule